// File: doc/BRIEF.md
# Glitch-Free Base/Half-Rate Clock Selector

This block derives a half-rate clock from a base clock and presents one of the two on a single output clock pin. A request input, launched from the base clock domain, states which clock the consumer wants. A logic 1 asks for the base clock and a logic 0 asks for the half-rate clock.

The choice that steers the output multiplexer is held in a small two-state machine. This machine is clocked on the falling edge of the base clock. It can move only at a falling edge where the half-rate clock is also low, so the steering value never changes while either source is high. Because of this, the output never shows a runt pulse. After a request arrives, the switch waits for the next legal falling edge, which is at most two base periods later.

The state machine has two states, `ST_HALF` (half-rate clock routed) and `ST_BASE` (base clock routed). It uses three transitions. `GO_BASE` runs from `ST_HALF` to `ST_BASE` when the request is 1 and the half-rate clock is low. `GO_HALF` runs from `ST_BASE` to `ST_HALF` when the request is 0 and the half-rate clock is low. `HOLD` keeps the state in every other case.

Top module: `clksel_glitchless`

## Requirements
- R1: While `rst_n` is low, the half-rate clock is held at 0, the state is `ST_HALF` and `clk_out` is 0.
- R2: The half-rate clock inverts at every rising edge of `clk_base` after reset. In `ST_HALF`, `clk_out` equals the half-rate clock, which is 1 after the first rising edge.
- R3: In `ST_BASE`, `clk_out` equals `clk_base`.
- R4: At a falling edge of `clk_base` where the half-rate clock is 0, the state becomes `ST_BASE` if `want_base` is 1, and `ST_HALF` if `want_base` is 0.
- R5: At a falling edge of `clk_base` where the half-rate clock is 1, the state keeps its value whatever `want_base` is.
- R6: After reset release, every high phase and every low phase of `clk_out` lasts at least half a `clk_base` period, including across switches in both directions.
- R7: A `want_base` pulse that is present only at falling edges where the half-rate clock is 1 leaves the routed clock unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_base | input | 1 | Base clock; the half-rate clock and the selector are both derived from it |
| rst_n | input | 1 | Asynchronous active-low reset |
| want_base | input | 1 | Request, synchronous to `clk_base`: 1 asks for the base clock, 0 for the half-rate clock |
| clk_out | output | 1 | Selected output clock |

## Verification
The selector samples the request at base falling edges, and the half-rate clock toggles at base rising edges. As a result, a request change and a half-rate phase boundary fall into the same base period. Whether the switch happens at once or is deferred depends on which half-rate phase the falling edge lands in. The bench changes the request just after rising edges in both half-rate phases, including a one-period pulse aimed at an illegal falling edge. It then compares `clk_out` against a behavioural model at a quarter period after every base edge, and it times each output phase so that any runt pulse at a switch is caught.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

    // Steering state: encoding is the multiplexer select (1 = base clock)
    typedef enum logic {
        ST_HALF = 1'b0,
        ST_BASE = 1'b1
    } route_state_e;

    // Named transitions of the steering machine
    typedef enum logic [1:0] {
        TR_HOLD    = 2'd0,
        TR_GO_BASE = 2'd1,
        TR_GO_HALF = 2'd2
    } route_move_e;

endpackage

// File: rtl/clksel_halfrate.sv
module clksel_halfrate #(
    parameter logic RESET_LEVEL = 1'b0
) (
    input  logic clk_base,
    input  logic rst_n,
    output logic half_clk
);

    logic level_q;

    // Inverts on every rising base edge: exact divide-by-two
    always_ff @(posedge clk_base or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= RESET_LEVEL;
        end else begin
            level_q <= ~level_q;
        end
    end

    assign half_clk = level_q;

endmodule

// File: rtl/clksel_route_fsm.sv
module clksel_route_fsm
    import clksel_pkg::*;
#(
    parameter route_state_e RESET_STATE = ST_HALF
) (
    input  logic clk_base,
    input  logic rst_n,
    input  logic want_base,
    input  logic half_clk,
    output logic route_base
);

    route_state_e state_q;
    route_state_e state_d;
    route_move_e  move;
    logic         window_open;

    // Legal instant: base falling edge with the half-rate clock low
    assign window_open = ~half_clk;

    always_comb begin
        move = TR_HOLD;
        unique case (state_q)
            ST_HALF: if (window_open && want_base)  move = TR_GO_BASE;
            ST_BASE: if (window_open && !want_base) move = TR_GO_HALF;
            default: move = TR_HOLD;
        endcase
    end

    always_comb begin
        unique case (move)
            TR_GO_BASE: state_d = ST_BASE;
            TR_GO_HALF: state_d = ST_HALF;
            default:    state_d = state_q;
        endcase
    end

    // State register on the falling edge of the base clock
    always_ff @(negedge clk_base or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RESET_STATE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output process
    always_comb begin
        unique case (state_q)
            ST_BASE: route_base = 1'b1;
            default: route_base = 1'b0;
        endcase
    end

endmodule

// File: rtl/clksel_gate_mux.sv
module clksel_gate_mux (
    input  logic route_base,
    input  logic clk_base,
    input  logic half_clk,
    output logic clk_out
);

    logic base_leg;
    logic half_leg;

    // AND-OR structure: each leg gated by its select term
    assign base_leg = route_base & clk_base;
    assign half_leg = ~route_base & half_clk;
    assign clk_out  = base_leg | half_leg;

endmodule

// File: rtl/clksel_glitchless.sv
module clksel_glitchless
    import clksel_pkg::*;
#(
    parameter logic HALF_RESET_LEVEL = 1'b0
) (
    input  logic clk_base,
    input  logic rst_n,
    input  logic want_base,
    output logic clk_out
);

    logic div_q;
    logic sel_q;

    clksel_halfrate #(
        .RESET_LEVEL (HALF_RESET_LEVEL)
    ) u_half (
        .clk_base (clk_base),
        .rst_n    (rst_n),
        .half_clk (div_q)
    );

    clksel_route_fsm #(
        .RESET_STATE (ST_HALF)
    ) u_fsm (
        .clk_base   (clk_base),
        .rst_n      (rst_n),
        .want_base  (want_base),
        .half_clk   (div_q),
        .route_base (sel_q)
    );

    clksel_gate_mux u_mux (
        .route_base (sel_q),
        .clk_base   (clk_base),
        .half_clk   (div_q),
        .clk_out    (clk_out)
    );

endmodule

// File: rtl/clksel_glitchless_chk.sv
module clksel_glitchless_chk (
    input logic clk_base,
    input logic rst_n,
    input logic want_base,
    input logic div_q,
    input logic sel_q,
    input logic clk_out
);

    logic armed;

    always_ff @(posedge clk_base or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    AST_DIV_TOGGLES: assert property (@(posedge clk_base) disable iff (!rst_n)
        armed |-> (div_q != $past(div_q)));                                  // R2

    AST_BASE_ROUTED: assert property (@(posedge clk_base) disable iff (!rst_n)
        sel_q |-> !clk_out);                                                  // R3

    AST_SEL_TAKES_REQ: assert property (@(negedge clk_base) disable iff (!rst_n)
        !div_q |=> (sel_q == $past(want_base)));                              // R4

    AST_SEL_HOLDS: assert property (@(negedge clk_base) disable iff (!rst_n)
        div_q |=> $stable(sel_q));                                            // R5

endmodule

bind clksel_glitchless clksel_glitchless_chk u_chk (
    .clk_base  (clk_base),
    .rst_n     (rst_n),
    .want_base (want_base),
    .div_q     (div_q),
    .sel_q     (sel_q),
    .clk_out   (clk_out)
);

// File: tb/clksel_glitchless_test.sv
`timescale 1ns/1ps
module clksel_glitchless_test;

    localparam real HALF_T = 2.5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic want_base = 1'b0;
    logic clk_out;

    int    n_vec  = 0;
    int    n_miss = 0;
    string tag    = "R1";
    bit    done   = 1'b0;

    // behavioural reference
    int m_half = 0;
    int m_route = 0;
    realtime last_edge = 0.0;
    bit      edge_seen = 1'b0;

    clksel_glitchless uut (
        .clk_base  (clk),
        .rst_n     (rst_n),
        .want_base (want_base),
        .clk_out   (clk_out)
    );

    always #(HALF_T) clk = ~clk;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_half <= 0;
        else        m_half <= 1 - m_half;
    end

    always @(negedge clk or negedge rst_n) begin
        if (!rst_n) m_route <= 0;
        else if (m_half == 0) m_route <= want_base ? 1 : 0;
    end

    task automatic cmp(input logic exp_v, input string rq);
        n_vec++;
        if (clk_out !== exp_v) begin
            n_miss++;
            $display("FAIL %s at %0t: clk_out=%b expected=%b", rq, $time, clk_out, exp_v);
        end
    endtask

    // compare every quarter period after each base edge
    initial begin
        forever begin
            @(posedge clk);
            #(HALF_T / 2);
            cmp((m_route == 1) ? 1'b1 : ((m_half == 1) ? 1'b1 : 1'b0), tag);
            @(negedge clk);
            #(HALF_T / 2);
            cmp((m_route == 1) ? 1'b0 : ((m_half == 1) ? 1'b1 : 1'b0), tag);
        end
    end

    // R6: minimum phase width on the output
    always @(clk_out) begin
        if (rst_n === 1'b1 && !done) begin
            if (edge_seen) begin
                n_vec++;
                if ($realtime - last_edge < HALF_T - 0.01) begin
                    n_miss++;
                    $display("FAIL R6 at %0t: phase width=%0f expected>=%0f",
                             $time, $realtime - last_edge, HALF_T);
                end
            end
            edge_seen = 1'b1;
            last_edge = $realtime;
        end
    end

    task automatic run_cycles(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000.0 * 2 * HALF_T);
        n_miss++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

    initial begin
        // R1: reset state
        tag = "R1";
        run_cycles(3);
        n_vec++;
        if (clk_out !== 1'b0) begin
            n_miss++;
            $display("FAIL R1: clk_out=%b expected=0 in reset", clk_out);
        end
        @(negedge clk); #1;
        rst_n = 1'b1;

        // R2: half-rate routed
        tag = "R2";
        run_cycles(8);

        // R4: switch to base, R3: base routed
        tag = "R4";
        want_base = 1'b1;
        run_cycles(3);
        tag = "R3";
        run_cycles(8);

        // R4: back to half rate
        tag = "R4";
        want_base = 1'b0;
        run_cycles(6);

        // R7/R5: pulse seen only at an illegal falling edge
        do begin
            @(posedge clk); #1;
        end while (m_half != 1);
        tag = "R7";
        want_base = 1'b1;
        @(posedge clk); #1;
        want_base = 1'b0;
        tag = "R5";
        run_cycles(6);

        // same pulse from the base-routed side
        want_base = 1'b1;
        run_cycles(6);
        do begin
            @(posedge clk); #1;
        end while (m_half != 1);
        tag = "R7";
        want_base = 1'b0;
        @(posedge clk); #1;
        want_base = 1'b1;
        tag = "R5";
        run_cycles(6);

        // R6: repeated switches with varied dwell and phase
        tag = "R6";
        for (int i = 0; i < 24; i++) begin
            want_base = ~want_base;
            run_cycles((i % 5) + 1);
        end
        run_cycles(6);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

endmodule